// File: doc/BRIEF.md
# Four-Bit Falling-Edge Up/Down Counter with Level Load

This block is a small binary counter whose state moves by one on every falling edge of its clock pin. A direction pin picks between incrementing and decrementing, and the count wraps around modulo 16 in both directions. A preset path copies a four-bit value into the state as soon as the clock is high and the load-enable pin is high together. It does not wait for a clock edge.

The next state is never produced as a plain value. A combinational stage forms a change mask instead: the bits that must flip to reach the next count, which is the present count XOR the wanted count. The state register applies the mask by XORing it back into its own contents. The mask also leaves the block on a port of its own, so neighbouring logic or a bench can observe it. The design has no streaming data path. Every pin is a plain control or status level, so no valid/ready handshake and no back-pressure apply.

Top module: `updn_fall_counter`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is 0. This holds even when `clk_c` and `ld_en` are both high.
- R2: With `dir_dn` = 0 and `ld_en` = 0, each falling edge of `clk_c` increases `cnt_q` by one.
- R3: With `dir_dn` = 1 and `ld_en` = 0, each falling edge of `clk_c` decreases `cnt_q` by one.
- R4: Counting wraps modulo 16. Counting up goes from 15 to 0, and counting down goes from 0 to 15.
- R5: When `clk_c` and `ld_en` are high at the same time, `cnt_q` takes the value of `ld_data` at once, without any clock edge.
- R6: A falling edge of `clk_c` while `ld_en` is high leaves `cnt_q` unchanged, so the loaded value is held.
- R7: `step_diff` is combinational. It equals `cnt_q` XOR (`cnt_q`+1) when `dir_dn` = 0, and `cnt_q` XOR (`cnt_q`-1) when `dir_dn` = 1. Its bit 0 is therefore always 1.
- R8: A rising edge of `clk_c` while `ld_en` is low does not change `cnt_q`.
- R9: Raising `ld_en` while `clk_c` is low does not change `cnt_q` until `clk_c` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_c | input | 1 | Counter clock. The state steps on its falling edge, and its high level enables the load path |
| rst_n | input | 1 | Asynchronous active-low clear. It has top priority |
| ld_en | input | 1 | Load enable. It loads while `clk_c` is high and blocks counting while it is high |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| ld_data | input | 4 | Value copied into the count during a load |
| cnt_q | output | 4 | Present count, bit 3 most significant |
| step_diff | output | 4 | Change mask that the next falling edge applies by XOR |

## Verification
The checks assume that `ld_data` is stable whenever `ld_en` is high. They also assume that `dir_dn` changes only while `clk_c` is low, and that reset is released while `ld_en` is low. The load path captures the value when the load condition starts, so a later change to `ld_data` would not be followed. The bench changes `dir_dn`, `ld_data` and `rst_n` only in the low half of the clock. It holds `ld_data` fixed for as long as `ld_en` is high. It raises `ld_en` in the high half only in the test for the immediate load, and `ld_data` is already settled there.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned CNT_W_DEF = 4;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/step_diff_gen.sv
// Change-mask generator: bit i flips when every lower bit is at the
// "carry" value (all ones counting up, all zeros counting down). R7
module step_diff_gen #(
  parameter int unsigned W = cnt_pkg::CNT_W_DEF
) (
  input  logic [W-1:0] cur,
  input  logic         dn,
  output logic [W-1:0] mask
);
  import cnt_pkg::*;

  logic [W-1:0] run;
  logic         inv;

  assign inv    = (dir_e'(dn) == DIR_DOWN);
  assign run[0] = 1'b1;

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign run[i] = run[i-1] & (cur[i-1] ^ inv);
  end

  assign mask = run;
endmodule

// File: rtl/state_reg.sv
// State register: async clear, level-started load, falling-edge XOR update.
module state_reg #(
  parameter int unsigned W = cnt_pkg::CNT_W_DEF
) (
  input  logic         clk_c,
  input  logic         rst_n,
  input  logic         ld_fire,
  input  logic         ld_hold,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q
);
  always_ff @(negedge clk_c or negedge rst_n or posedge ld_fire) begin
    if (!rst_n) begin
      q <= '0;                 // R1
    end else if (ld_fire) begin
      q <= ld_val;             // R5
    end else if (ld_hold) begin
      q <= q;                  // R6
    end else begin
      q <= q ^ flip;           // R2 R3 R4
    end
  end
endmodule

// File: rtl/updn_fall_counter.sv
module updn_fall_counter #(
  parameter int unsigned W = cnt_pkg::CNT_W_DEF
) (
  input  logic         clk_c,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic         dir_dn,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] step_diff
);
  logic         ld_fire;
  logic [W-1:0] mask;

  // Load condition: clock high and enable high together (R5, R9)
  assign ld_fire = clk_c & ld_en;

  step_diff_gen #(.W(W)) u_diff (
    .cur  (cnt_q),
    .dn   (dir_dn),
    .mask (mask)
  );

  state_reg #(.W(W)) u_state (
    .clk_c   (clk_c),
    .rst_n   (rst_n),
    .ld_fire (ld_fire),
    .ld_hold (ld_en),
    .ld_val  (ld_data),
    .flip    (mask),
    .q       (cnt_q)
  );

  assign step_diff = mask;
endmodule

// File: rtl/updn_fall_counter_chk.sv
module updn_fall_counter_chk #(
  parameter int unsigned W = cnt_pkg::CNT_W_DEF
) (
  input logic         clk_c,
  input logic         rst_n,
  input logic         ld_en,
  input logic         dir_dn,
  input logic [W-1:0] ld_data,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] step_diff
);
  localparam logic [W-1:0] ONE = 1;

  assert_reset_clear_R1: assert property (@(posedge clk_c)
    !rst_n |-> (cnt_q == '0));

  // R2 and R4: the step up wraps through modulo arithmetic
  assert_count_up_R2: assert property (@(negedge clk_c) disable iff (!rst_n || ld_en)
    !dir_dn |=> (cnt_q == $past(cnt_q) + ONE));

  // R3 and R4: the step down wraps through modulo arithmetic
  assert_count_down_R3: assert property (@(negedge clk_c) disable iff (!rst_n || ld_en)
    dir_dn |=> (cnt_q == $past(cnt_q) - ONE));

  assert_load_track_R5: assert property (@(negedge clk_c) disable iff (!rst_n)
    ld_en |-> (cnt_q == ld_data));

  assert_diff_up_R7: assert property (@(posedge clk_c) disable iff (!rst_n)
    !dir_dn |-> ((cnt_q ^ step_diff) == cnt_q + ONE));

  assert_diff_down_R7: assert property (@(posedge clk_c) disable iff (!rst_n)
    dir_dn |-> ((cnt_q ^ step_diff) == cnt_q - ONE));

  assert_diff_lsb_R7: assert property (@(posedge clk_c) disable iff (!rst_n)
    step_diff[0]);
endmodule

bind updn_fall_counter updn_fall_counter_chk #(.W(W)) u_chk (.*);

// File: tb/updn_fall_counter_bench.sv
module updn_fall_counter_bench;
  localparam int W = 4;

  logic         clk_c;
  logic         rst_n;
  logic         ld_en;
  logic         dir_dn;
  logic [W-1:0] ld_data;
  logic [W-1:0] cnt_q;
  logic [W-1:0] step_diff;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic [W-1:0] model;

  updn_fall_counter #(.W(W)) u_updn_fall_counter (
    .clk_c     (clk_c),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .dir_dn    (dir_dn),
    .ld_data   (ld_data),
    .cnt_q     (cnt_q),
    .step_diff (step_diff)
  );

  // 50 MHz: 20 ns period. Falling edges at 10, 30, 50 ...
  initial clk_c = 1'b1;
  always #10 clk_c = ~clk_c;

  // Each entry: {direction, expected count after the next falling edge}
  localparam logic [4:0] VEC [10] = '{
    {1'b0, 4'd14}, {1'b0, 4'd15}, {1'b0, 4'd0},  {1'b0, 4'd1},
    {1'b1, 4'd0},  {1'b1, 4'd15}, {1'b1, 4'd14}, {1'b0, 4'd15},
    {1'b0, 4'd0},  {1'b1, 4'd15}
  };

  function automatic logic [W-1:0] want_mask(logic [W-1:0] q, logic dn);
    logic [W-1:0] nx;
    nx = dn ? q - 4'd1 : q + 4'd1;
    return q ^ nx;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_q(string req, logic [W-1:0] exp);
    chk(cnt_q == exp, req, cnt_q, exp);
  endtask

  task automatic chk_mask(string req);
    chk(step_diff == want_mask(cnt_q, dir_dn), req, step_diff, want_mask(cnt_q, dir_dn));
  endtask

  // Move to the low half, 5 ns after the falling edge
  task automatic low_half();
    @(negedge clk_c);
    #5;
  endtask

  initial begin
    rst_n = 1'b1; ld_en = 1'b0; dir_dn = 1'b0; ld_data = '0;
    #5 rst_n = 1'b0;
    low_half();
    chk_q("R1", 4'd0);

    // R1: reset wins over an active load
    ld_data = 4'd9; ld_en = 1'b1;
    @(posedge clk_c); #5;
    chk_q("R1", 4'd0);
    low_half();
    ld_en = 1'b0; rst_n = 1'b1;
    #1;
    chk_q("R1", 4'd0);
    chk_mask("R7");
    dir_dn = 1'b1; #1;
    chk_mask("R7");
    dir_dn = 1'b0;

    // R9 then R5 then R6: load 13
    ld_data = 4'd13; ld_en = 1'b1; #1;
    chk_q("R9", 4'd0);
    @(posedge clk_c); #5;
    chk_q("R5", 4'd13);
    chk_mask("R7");
    low_half();
    chk_q("R6", 4'd13);
    ld_en = 1'b0;
    model = 4'd13;

    // Vector walk: R2, R3, R4, R7, R8
    for (int i = 0; i < 10; i++) begin
      string tag;
      dir_dn = VEC[i][4];
      #1;
      chk_mask("R7");
      @(posedge clk_c); #5;
      chk_q("R8", model);
      if ((!VEC[i][4] && model == 4'd15) || (VEC[i][4] && model == 4'd0)) tag = "R4";
      else tag = VEC[i][4] ? "R3" : "R2";
      low_half();
      chk_q(tag, VEC[i][3:0]);
      model = VEC[i][3:0];
    end

    // R6: load 0, hold through two falling edges in both directions
    ld_data = 4'd0; ld_en = 1'b1; dir_dn = 1'b0;
    low_half();
    chk_q("R6", 4'd0);
    dir_dn = 1'b1;
    low_half();
    chk_q("R6", 4'd0);
    ld_en = 1'b0;
    low_half();
    chk_q("R4", 4'd15);

    // R5: a load raised in the high half takes effect with no edge
    dir_dn = 1'b0;
    @(posedge clk_c); #5;
    chk_q("R8", 4'd15);
    ld_data = 4'd6; ld_en = 1'b1; #1;
    chk_q("R5", 4'd6);
    low_half();
    chk_q("R6", 4'd6);
    ld_en = 1'b0;
    low_half();
    chk_q("R2", 4'd7);

    // R1: asynchronous clear in the middle of counting
    rst_n = 1'b0; #1;
    chk_q("R1", 4'd0);
    low_half();
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule